// File: doc/BRIEF.md
# Serial Configuration Shift-In Slave

This block loads the device configuration from an external processor over two wires. When the configuration-mode strap is held low, the clock and data pins become inputs. The processor drives a slow serial clock, up to 8 MHz, and a data line. The block samples the data line on every rising edge of that serial clock and fills a file of 54 eight-bit configuration registers. It starts with register 0 and ends with register 53, and within each register it takes the most significant bit first.

The serial stream carries no framing and no addressing. The block counts edges and nothing else. Register 0 gets only seven clocks, for bits 6 down to 0; its bit 7 is never clocked and stays at zero. Each later register gets eight clocks. After exactly 431 rising edges, the block raises a sticky ready flag that releases the rest of the device. From then on, extra clocks change nothing until reset.

Both pins are asynchronous to the system clock. They pass through a two-stage synchronizer, and rising edges are found in the system domain. This requires a system clock of at least four times the serial clock rate. The data line must be stable for several system cycles around each rising edge.

Top module: `cfg_shift_slave`

## Requirements
- R1: After reset, ready_o is 0 and every bit of cfg_o is 0.
- R2: While the mode strap is low, each rising edge of scl_i stores exactly one sda_i bit. Falling edges of scl_i, and changes of sda_i while scl_i is steady, leave cfg_o unchanged.
- R3: The first 7 rising edges fill register 0, bits 6 down to 0 in that order. Register 0 bit 7 (cfg_o[7]) stays 0 whatever data is sent.
- R4: Register k sits at cfg_o[8k+7:8k]. For k from 1 to 53, the rising edge with 0-based index 7+8(k-1)+(7-b) writes bit b of register k.
- R5: ready_o stays 0 after 430 rising edges. It is 1 no more than 6 system clocks after the 431st rising edge.
- R6: Once ready_o is 1, it stays 1 until reset.
- R7: Rising edges of scl_i after ready_o is 1 leave cfg_o unchanged.
- R8: While cfg_mode_ni is high, rising edges of scl_i neither change cfg_o nor advance the bit position. A stream sent after the strap goes low therefore still starts at register 0 bit 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 4x the serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_mode_ni | input | 1 | Mode strap; low selects processor shift-in |
| scl_i | input | 1 | Serial clock from the processor |
| sda_i | input | 1 | Serial data from the processor |
| ready_o | output | 1 | High once all registers are loaded |
| cfg_o | output | 432 | Register file; register k at bits [8k+7:8k] |

## Verification
The write of the final bit, into register 53 bit 0, and the setting of ready fall in the same system cycle. Any error there shows up either as ready rising one edge early or late, or as a lost last bit. The bench checks that ready is still low after 430 edges. It then sends the 431st edge and compares register 53 bit 0 together with ready. A second collision, extra rising edges arriving right after ready, is provoked by continuing to clock data into the block. The bench judges it by comparing the whole register file before and after.

// File: rtl/cfg_shift_pkg.sv
`timescale 1ns/1ps
package cfg_shift_pkg;
  typedef enum logic [0:0] {
    SEQ_LOAD = 1'b0,
    SEQ_DONE = 1'b1
  } seq_state_e;

  // bit position of the first clocked bit of register 0
  function automatic int unsigned first_bit_pos(int unsigned reg_w, int unsigned skip);
    return reg_w - 1 - skip;
  endfunction
endpackage

// File: rtl/cfg_sync.sv
`timescale 1ns/1ps
module cfg_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          stg_q[s] <= RST_VAL;
        end else if (s == 0) begin
          stg_q[s] <= d_i;
        end else begin
          stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cfg_edge_det.sv
`timescale 1ns/1ps
module cfg_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R2
endmodule

// File: rtl/cfg_bit_seq.sv
`timescale 1ns/1ps
module cfg_bit_seq
  import cfg_shift_pkg::*;
#(
  parameter int unsigned NUM_REGS = 54,
  parameter int unsigned REG_W    = 8,
  parameter int unsigned SKIP     = 1,
  localparam int unsigned IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int unsigned BIT_W   = (REG_W > 1) ? $clog2(REG_W) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] reg_sel_o,
  output logic [BIT_W-1:0] bit_sel_o,
  output logic             done_o
);
  localparam logic [IDX_W-1:0] LAST_REG  = IDX_W'(NUM_REGS - 1);
  localparam logic [BIT_W-1:0] TOP_BIT   = BIT_W'(REG_W - 1);
  localparam logic [BIT_W-1:0] FIRST_BIT = BIT_W'(first_bit_pos(REG_W, SKIP));

  seq_state_e       state_q;
  logic [IDX_W-1:0] reg_ptr_q;
  logic [BIT_W-1:0] bit_ptr_q;
  logic             last_bit;

  assign wr_en_o   = shift_i && (state_q == SEQ_LOAD);
  assign reg_sel_o = reg_ptr_q;
  assign bit_sel_o = bit_ptr_q;
  assign done_o    = (state_q == SEQ_DONE);
  assign last_bit  = (bit_ptr_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= SEQ_LOAD;
      reg_ptr_q <= '0;
      bit_ptr_q <= FIRST_BIT;
    end else if (wr_en_o) begin
      if (last_bit) begin
        if (reg_ptr_q == LAST_REG) begin
          state_q <= SEQ_DONE;
        end else begin
          reg_ptr_q <= reg_ptr_q + 1'b1;
          bit_ptr_q <= TOP_BIT;
        end
      end else begin
        bit_ptr_q <= bit_ptr_q - 1'b1;
      end
    end
  end

  AST_PTR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_ptr_q <= LAST_REG); // R4
  AST_FIRST_REG_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_ptr_q == '0) |-> (bit_ptr_q <= FIRST_BIT)); // R3
  AST_DONE_ON_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(wr_en_o && reg_ptr_q == LAST_REG && bit_ptr_q == '0)); // R5
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o); // R6
endmodule

// File: rtl/cfg_reg_file.sv
`timescale 1ns/1ps
module cfg_reg_file #(
  parameter int unsigned NUM_REGS = 54,
  parameter int unsigned REG_W    = 8,
  parameter int unsigned SKIP     = 1,
  localparam int unsigned IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int unsigned BIT_W   = (REG_W > 1) ? $clog2(REG_W) : 1,
  localparam int unsigned TOT_W   = NUM_REGS * REG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] reg_sel_i,
  input  logic [BIT_W-1:0] bit_sel_i,
  input  logic             data_i,
  output logic [TOT_W-1:0] cfg_o
);
  genvar k;
  generate
    for (k = 0; k < NUM_REGS; k++) begin : g_reg
      logic [REG_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          q <= '0;
        end else if (wr_en_i && (reg_sel_i == IDX_W'(k))) begin
          q[bit_sel_i] <= data_i;
        end
      end
      assign cfg_o[k*REG_W +: REG_W] = q;
    end
  endgenerate

  AST_ONE_BIT_PER_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ($countones(cfg_o ^ $past(cfg_o)) <= 1)); // R2
  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(cfg_o)); // R7

  generate
    if (SKIP > 0) begin : g_skip_chk
      AST_R0_MSB_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cfg_o[REG_W-1]); // R3
    end
  endgenerate
endmodule

// File: rtl/cfg_shift_slave.sv
`timescale 1ns/1ps
module cfg_shift_slave #(
  parameter int unsigned NUM_REGS    = 54,
  parameter int unsigned REG_W       = 8,
  parameter int unsigned SKIP        = 1,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned IDX_W      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int unsigned BIT_W      = (REG_W > 1) ? $clog2(REG_W) : 1,
  localparam int unsigned TOT_W      = NUM_REGS * REG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_mode_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             ready_o,
  output logic [TOT_W-1:0] cfg_o
);
  logic [2:0]       pin_s;
  logic             scl_s, sda_s, mode_act;
  logic             scl_rise, shift;
  logic             wr_en;
  logic [IDX_W-1:0] reg_sel;
  logic [BIT_W-1:0] bit_sel;

  // mode strap resets to inactive (high)
  cfg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cfg_mode_ni, sda_i, scl_i}),
    .q_o   (pin_s)
  );

  assign scl_s    = pin_s[0];
  assign sda_s    = pin_s[1];
  assign mode_act = ~pin_s[2];

  cfg_edge_det u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (scl_s),
    .rise_o(scl_rise)
  );

  assign shift = scl_rise & mode_act;

  cfg_bit_seq #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .SKIP(SKIP)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .shift_i  (shift),
    .wr_en_o  (wr_en),
    .reg_sel_o(reg_sel),
    .bit_sel_o(bit_sel),
    .done_o   (ready_o)
  );

  cfg_reg_file #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .SKIP(SKIP)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .reg_sel_i(reg_sel),
    .bit_sel_i(bit_sel),
    .data_i   (sda_s),
    .cfg_o    (cfg_o)
  );

  AST_MODE_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_act |=> ($stable(cfg_o) && $stable(ready_o))); // R8
  AST_READY_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> $stable(cfg_o)); // R7
  AST_READY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o); // R6
endmodule

// File: tb/cfg_shift_slave_bench.sv
`timescale 1ns/1ps
module cfg_shift_slave_bench;
  localparam int NUM_REGS = 54;
  localparam int REG_W    = 8;
  localparam int TOTAL    = 431;
  localparam int TOT_W    = NUM_REGS * REG_W;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, mode_n, scl, sda, ready;
  logic [TOT_W-1:0] cfg;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  logic [7:0] img [NUM_REGS];

  cfg_shift_slave u_cfg_shift_slave (
    .clk_i(clk), .rst_ni(rst_n), .cfg_mode_ni(mode_n),
    .scl_i(scl), .sda_i(sda), .ready_o(ready), .cfg_o(cfg)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic bit_of(input int g);
    if (g < 7) return img[0][6-g];
    return img[1 + (g-7)/8][7 - ((g-7)%8)];
  endfunction

  function automatic logic [7:0] exp_reg(input int k);
    return (k == 0) ? {1'b0, img[0][6:0]} : img[k];
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk); sda = b;
    repeat (4) @(negedge clk); scl = 1'b1;
    repeat (4) @(negedge clk); scl = 1'b0;
  endtask

  task automatic send_range(input int from, input int to);
    for (int g = from; g < to; g++) send_bit(bit_of(g));
  endtask

  task automatic check_all(input string req);
    for (int k = 0; k < NUM_REGS; k++)
      chk(cfg[k*REG_W +: REG_W] == exp_reg(k), req, 32'(cfg[k*REG_W +: REG_W]), 32'(exp_reg(k)));
  endtask

  task automatic do_reset();
    rst_n = 1'b0; scl = 1'b0; sda = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog act=0x0 exp=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [TOT_W-1:0] snap;
    logic dummy;
    rst_n = 1'b0; mode_n = 1'b0; scl = 1'b0; sda = 1'b0;
    dummy = $urandom(32'd2024);
    do_reset();
    // R1 reset state
    chk(ready == 1'b0, "R1 ready", 32'(ready), 0);
    chk(cfg == '0, "R1 cfg", cfg[31:0], 0);

    // directed image: reg0 all ones, bit 7 must stay 0
    for (int k = 0; k < NUM_REGS; k++) img[k] = 8'hA5 ^ 8'(k);
    img[0] = 8'hFF;
    send_range(0, 7);
    repeat (6) @(negedge clk);
    chk(cfg[7:0] == 8'h7F, "R3 reg0", 32'(cfg[7:0]), 32'h7F);
    // R2: sda toggles while scl low do nothing
    snap = cfg;
    for (int i = 0; i < 4; i++) begin @(negedge clk); sda = ~sda; end
    repeat (4) @(negedge clk);
    chk(cfg == snap, "R2 sda_only", cfg[31:0], snap[31:0]);
    // R2: rising edge stores, falling edge does not
    @(negedge clk); sda = bit_of(7);
    repeat (4) @(negedge clk); scl = 1'b1;
    repeat (6) @(negedge clk);
    chk(cfg[15] == bit_of(7), "R2 rise_store", 32'(cfg[15]), 32'(bit_of(7)));
    snap = cfg;
    sda = ~sda;
    repeat (2) @(negedge clk); scl = 1'b0;
    repeat (6) @(negedge clk);
    chk(cfg == snap, "R2 fall_noeffect", cfg[31:0], snap[31:0]);
    send_range(8, TOTAL-1);
    repeat (6) @(negedge clk);
    chk(ready == 1'b0, "R5 early", 32'(ready), 0);
    send_bit(bit_of(TOTAL-1));
    repeat (6) @(negedge clk);
    chk(ready == 1'b1, "R5 ready", 32'(ready), 1);
    chk(cfg[53*8] == img[53][0], "R5 last_bit", 32'(cfg[53*8]), 32'(img[53][0]));
    check_all("R4 image_a");

    // R7 extra clocks after ready
    snap = cfg;
    for (int i = 0; i < 16; i++) send_bit(~bit_of(i));
    repeat (6) @(negedge clk);
    chk(cfg == snap, "R7 frozen", cfg[31:0], snap[31:0]);
    chk(ready == 1'b1, "R6 sticky", 32'(ready), 1);

    // R8 strap high
    mode_n = 1'b1;
    do_reset();
    for (int k = 0; k < NUM_REGS; k++) img[k] = 8'($urandom);
    for (int i = 0; i < 40; i++) send_bit(1'b1);
    repeat (6) @(negedge clk);
    chk(cfg == '0, "R8 cfg_untouched", cfg[31:0], 0);
    chk(ready == 1'b0, "R8 no_ready", 32'(ready), 0);
    mode_n = 1'b0;
    repeat (6) @(negedge clk);
    send_range(0, TOTAL);
    repeat (6) @(negedge clk);
    chk(ready == 1'b1, "R8 ready_after", 32'(ready), 1);
    check_all("R8 R4 image_b");

    // random image with zero/ones corners
    do_reset();
    chk(ready == 1'b0, "R1 ready_rst2", 32'(ready), 0);
    for (int k = 0; k < NUM_REGS; k++) img[k] = 8'($urandom);
    img[1] = 8'h00; img[52] = 8'hFF; img[0] = 8'h80;
    send_range(0, TOTAL);
    repeat (6) @(negedge clk);
    chk(ready == 1'b1, "R5 ready_c", 32'(ready), 1);
    check_all("R4 image_c");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule